// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Tap

This block forms one stage of a multiply-and-add chain. It multiplies two signed 12-bit operands, registers the 24-bit product, sign-extends it to 26 bits and adds a separate signed 26-bit addend. Each of the three operands has its own capture register with its own load enable. A chain of these stages can form a transposed FIR filter, with the sum of one stage feeding the addend of the next. The same stage can also evaluate a polynomial by Horner's rule.

The adder result is also loaded into a sum register on every clock edge. A runtime select chooses what drives the output port: the adder directly, or the sum register one cycle later. The direct path is the normal filter path. The registered path adds one cycle of delay. That delay can stand in for a zero-coefficient tap, or let two interleaved sample streams share the stage on alternate cycles. An active-high output-off control forces the output data to zero and clears a valid flag.

Top module: `mac_tap`

## Requirements
- R1: While `rst_n` is low at a rising edge, the A, B, C, product and sum registers are cleared. With `feedthrough`=1 and `out_off`=0, the output therefore reads 0 once reset has been applied.
- R2: The A register loads `a_in` at a rising edge only when `en_a`=1. Otherwise it keeps its value.
- R3: The B register loads `b_in` at a rising edge only when `en_b`=1. Otherwise it keeps its value.
- R4: The C register loads `c_in` at a rising edge only when `en_c`=1. Otherwise it keeps its value.
- R5: On every rising edge the product register takes the signed two's complement product of the A and B registers, 24 bits wide. The extreme case is -2048 * -2048 = 4194304.
- R6: The adder sign-extends the product register to 26 bits and adds the C register, wrapping modulo 2^26 with no saturation.
- R7: With `feedthrough`=1, `sum_out` shows the adder result in the same cycle.
- R8: With `feedthrough`=0, `sum_out` shows the sum register, which holds the adder result of the previous cycle.
- R9: With `out_off`=1, `sum_out` is all zeros and `sum_valid`=0. With `out_off`=0, `sum_valid`=1.
- R10: A/B values loaded at edge k reach `sum_out` after edge k+1 when `feedthrough`=1, and after edge k+2 when `feedthrough`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_a | input | 1 | Load enable for the A register |
| en_b | input | 1 | Load enable for the B register |
| en_c | input | 1 | Load enable for the C register |
| a_in | input | 12 | Multiplicand, two's complement |
| b_in | input | 12 | Multiplier, two's complement |
| c_in | input | 26 | Addend, two's complement |
| feedthrough | input | 1 | 1: adder drives output; 0: sum register drives output |
| out_off | input | 1 | 1: output forced to zero and marked invalid |
| sum_out | output | 26 | Sum output, two's complement |
| sum_valid | output | 1 | High when output is enabled |

## Verification
The bench sweeps A across its full range against the most negative, zero, unit and most positive values of B. Getting the product sign wrong, or zero-extending instead of sign-extending, makes every negative product come out wrong by a large margin. The extreme case -2048 * -2048 is paired with the largest positive addend. A design that saturated, or that lost the product's top bit, would show a value other than the wrapped negative sum. Each enable is held low at random in its own phase, so a register that ignores its enable shows up as a sample mismatch. Directed latency runs with both output paths, plus random toggling of `feedthrough` and `out_off`, catch an output select that is inverted or off by one cycle.

// File: rtl/mac_tap_pkg.sv
// Package: shared types for the multiply-accumulate tap.
// Assumes: nothing beyond IEEE 1800-2017.
package mac_tap_pkg;

    // Output source select, as decoded from the feedthrough pin.
    typedef enum logic {
        OUT_REGISTERED = 1'b0,
        OUT_DIRECT     = 1'b1
    } out_src_e;

endpackage

// File: rtl/mac_tap_inreg.sv
// Module: operand capture registers for A, B and C.
// Each register loads on a rising edge only when its own enable is high.
// Assumes: synchronous active-low reset clears every register to zero.
module mac_tap_inreg #(
    parameter int A_W = 12,
    parameter int B_W = 12,
    parameter int C_W = 26
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_a,
    input  logic                  en_b,
    input  logic                  en_c,
    input  logic signed [A_W-1:0] a_in,
    input  logic signed [B_W-1:0] b_in,
    input  logic signed [C_W-1:0] c_in,
    output logic signed [A_W-1:0] a_q,
    output logic signed [B_W-1:0] b_q,
    output logic signed [C_W-1:0] c_q
);

    // Capture the multiplicand when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)    a_q <= '0;
        else if (en_a) a_q <= a_in;
    end

    // Capture the multiplier when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)    b_q <= '0;
        else if (en_b) b_q <= b_in;
    end

    // Capture the addend when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)    c_q <= '0;
        else if (en_c) c_q <= c_in;
    end

    assert_hold_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_a |=> $stable(a_q));
    assert_load_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_a |=> a_q == $past(a_in));
    assert_hold_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_b |=> $stable(b_q));
    assert_hold_c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_c |=> $stable(c_q));

endmodule

// File: rtl/mac_tap_mult.sv
// Module: signed multiplier with a product register loaded every edge.
// Assumes: operands are two's complement; the product width is the sum of
// the operand widths, so no product ever overflows.
module mac_tap_mult #(
    parameter int A_W = 12,
    parameter int B_W = 12,
    localparam int P_W = A_W + B_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic signed [A_W-1:0] a_q,
    input  logic signed [B_W-1:0] b_q,
    output logic signed [P_W-1:0] prod_q
);

    logic signed [P_W-1:0] a_ext;
    logic signed [P_W-1:0] b_ext;

    // Widen both operands to the product width before multiplying.
    always_comb begin
        a_ext = P_W'(a_q);
        b_ext = P_W'(b_q);
    end

    // Register the full-width product on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= a_ext * b_ext;
    end

    // Product sign follows the operand signs when neither operand is zero.
    assert_prod_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_q != '0 && b_q != '0) |=> prod_q[P_W-1] == ($past(a_q[A_W-1]) ^ $past(b_q[B_W-1])));
    assert_prod_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_q == '0 || b_q == '0) |=> prod_q == '0);

endmodule

// File: rtl/mac_tap_summer.sv
// Module: sign-extending adder, sum register and output select/gating.
// Assumes: the sum is at least as wide as the product; addition wraps.
module mac_tap_summer
    import mac_tap_pkg::*;
#(
    parameter int P_W = 24,
    parameter int S_W = 26
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic signed [P_W-1:0] prod_q,
    input  logic signed [S_W-1:0] c_q,
    input  logic                  feedthrough,
    input  logic                  out_off,
    output logic        [S_W-1:0] sum_out,
    output logic                  sum_valid
);

    logic signed [S_W-1:0] prod_ext;
    logic signed [S_W-1:0] sum_comb;
    logic signed [S_W-1:0] sum_q;
    out_src_e              src;

    // Sign-extend the product up to the sum width (or trim if equal).
    generate
        if (S_W > P_W) begin : g_sext
            assign prod_ext = {{(S_W-P_W){prod_q[P_W-1]}}, prod_q};
        end else begin : g_trim
            assign prod_ext = prod_q[S_W-1:0];
        end
    endgenerate

    // Wrapping add of the extended product and the addend.
    always_comb sum_comb = prod_ext + c_q;

    // Load the sum register on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_comb;
    end

    // Pick the output source and apply the output-off gate.
    always_comb begin
        src       = feedthrough ? OUT_DIRECT : OUT_REGISTERED;
        sum_valid = !out_off;
        if (out_off)                sum_out = '0;
        else if (src == OUT_DIRECT) sum_out = sum_comb;
        else                        sum_out = sum_q;
    end

    assert_off_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_off |-> (sum_out == '0 && !sum_valid));
    assert_on_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_off |-> sum_valid);
    assert_reg_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_off && !feedthrough && $past(rst_n)) |-> sum_out == $past(sum_comb));

endmodule

// File: rtl/mac_tap.sv
// Module: top of one multiply-accumulate tap, computing A*B + C.
// Assumes: synchronous active-low reset; all data in two's complement.
module mac_tap #(
    parameter int A_W = 12,
    parameter int B_W = 12,
    parameter int S_W = 26,
    localparam int P_W = A_W + B_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_a,
    input  logic           en_b,
    input  logic           en_c,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic [S_W-1:0] c_in,
    input  logic           feedthrough,
    input  logic           out_off,
    output logic [S_W-1:0] sum_out,
    output logic           sum_valid
);

    logic signed [A_W-1:0] a_q;
    logic signed [B_W-1:0] b_q;
    logic signed [S_W-1:0] c_q;
    logic signed [P_W-1:0] prod_q;

    mac_tap_inreg #(.A_W(A_W), .B_W(B_W), .C_W(S_W)) u_inreg (
        .clk(clk), .rst_n(rst_n),
        .en_a(en_a), .en_b(en_b), .en_c(en_c),
        .a_in(signed'(a_in)), .b_in(signed'(b_in)), .c_in(signed'(c_in)),
        .a_q(a_q), .b_q(b_q), .c_q(c_q)
    );

    mac_tap_mult #(.A_W(A_W), .B_W(B_W)) u_mult (
        .clk(clk), .rst_n(rst_n),
        .a_q(a_q), .b_q(b_q), .prod_q(prod_q)
    );

    mac_tap_summer #(.P_W(P_W), .S_W(S_W)) u_summer (
        .clk(clk), .rst_n(rst_n),
        .prod_q(prod_q), .c_q(c_q),
        .feedthrough(feedthrough), .out_off(out_off),
        .sum_out(sum_out), .sum_valid(sum_valid)
    );

    // A reset edge leaves a zero output on the direct path (R1).
    assert_reset_zero_R1: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |-> (out_off || !feedthrough || sum_out == '0));

endmodule

// File: tb/mac_tap_tb.sv
module mac_tap_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_a = 1'b1, en_b = 1'b1, en_c = 1'b1;
    logic [11:0] a_in = '0, b_in = '0;
    logic [25:0] c_in = '0;
    logic        feedthrough = 1'b1, out_off = 1'b0;
    logic [25:0] sum_out;
    logic        sum_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench-side reference registers, updated from the requirements.
    logic signed [11:0] ma = '0, mb = '0;
    logic signed [25:0] mc = '0, ms = '0;
    logic signed [23:0] mp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_tap u_dut (
        .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b), .en_c(en_c),
        .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .feedthrough(feedthrough), .out_off(out_off),
        .sum_out(sum_out), .sum_valid(sum_valid)
    );

    function automatic logic [25:0] ref_sum();
        return {{2{mp[23]}}, mp} + mc;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ma <= '0; mb <= '0; mc <= '0; mp <= '0; ms <= '0;
        end else begin
            if (en_a) ma <= signed'(a_in);
            if (en_b) mb <= signed'(b_in);
            if (en_c) mc <= signed'(c_in);
            mp <= 24'(ma * mb);
            ms <= ref_sum();
        end
    end

    task automatic check(input string tag, input logic [25:0] exp_d, input logic exp_v);
        checks++;
        if (sum_out !== exp_d || sum_valid !== exp_v) begin
            failures++;
            $display("FAIL %s: sum_out=%0d valid=%0b expected sum_out=%0d valid=%0b",
                     tag, $signed(sum_out), sum_valid, $signed(exp_d), exp_v);
        end
    endtask

    // Compare against the reference at the falling edge.
    task automatic check_model(input string tag);
        logic [25:0] e;
        if (out_off)          e = '0;
        else if (feedthrough) e = ref_sum();
        else                  e = ms;
        check(tag, e, !out_off);
    endtask

    task automatic step(input string tag);
        @(negedge clk);
        check_model(tag);
    endtask

    // Directed latency probe: A*B loaded once, then zeros.
    task automatic latency(input logic ft);
        @(negedge clk);
        feedthrough = ft; out_off = 0; en_a = 1; en_b = 1; en_c = 1;
        a_in = 12'd3; b_in = 12'd5; c_in = '0;
        @(negedge clk);
        a_in = '0; b_in = '0;
        check("R10", 26'd0, 1'b1);
        @(negedge clk);
        check("R10", ft ? 26'd15 : 26'd0, 1'b1);
        @(negedge clk);
        check("R10", ft ? 26'd0 : 26'd15, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: expired expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset with busy inputs, direct path.
        a_in = 12'h7FF; b_in = 12'h7FF; c_in = 26'h155555;
        repeat (3) @(negedge clk);
        check("R1", 26'd0, 1'b1);
        feedthrough = 0;
        @(negedge clk);
        check("R1", 26'd0, 1'b1);
        a_in = '0; b_in = '0; c_in = '0; feedthrough = 1;
        rst_n = 1;
        @(negedge clk);

        latency(1'b1);
        latency(1'b0);

        // R5/R6/R7: sweep A over its range against edge values of B.
        feedthrough = 1; en_a = 1; en_b = 1; en_c = 1;
        for (int bi = 0; bi < 5; bi++) begin
            for (int av = -2048; av < 2048; av += 37) begin
                a_in = 12'(av);
                case (bi)
                    0: b_in = 12'h800;
                    1: b_in = 12'hFFF;
                    2: b_in = 12'h000;
                    3: b_in = 12'h001;
                    default: b_in = 12'h7FF;
                endcase
                c_in = 26'($urandom);
                step("R5");
            end
        end

        // R6: extreme product plus largest addend wraps negative.
        a_in = 12'h800; b_in = 12'h800; c_in = 26'h1FFFFFF;
        @(negedge clk);
        @(negedge clk);
        check("R6", 26'(4194304 + 33554431), 1'b1);
        check_model("R6");
        c_in = 26'h2000000;
        @(negedge clk);
        check("R6", 26'(4194304 - 33554432), 1'b1);

        // R2/R3/R4: each enable randomised in turn.
        for (int ph = 0; ph < 3; ph++) begin
            for (int i = 0; i < 600; i++) begin
                @(negedge clk);
                check_model(ph == 0 ? "R2" : (ph == 1 ? "R3" : "R4"));
                en_a = (ph == 0) ? 1'($urandom) : 1'b1;
                en_b = (ph == 1) ? 1'($urandom) : 1'b1;
                en_c = (ph == 2) ? 1'($urandom) : 1'b1;
                feedthrough = 1'($urandom);
                a_in = 12'($urandom); b_in = 12'($urandom); c_in = 26'($urandom);
            end
        end

        // R7/R8/R9: random select, output-off and enables.
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            check_model(out_off ? "R9" : (feedthrough ? "R7" : "R8"));
            en_a = 1'($urandom); en_b = 1'($urandom); en_c = 1'($urandom);
            feedthrough = 1'($urandom);
            out_off = (($urandom % 4) == 0);
            a_in = 12'($urandom); b_in = 12'($urandom); c_in = 26'($urandom);
        end

        // R9: explicit output-off check.
        out_off = 1;
        #1;
        check("R9", 26'd0, 1'b0);
        out_off = 0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule